// File: doc/BRIEF.md
# Lockable Watchdog Timer with Feed Sequence

This block guards a system against software that stops making progress. Software programs a reload value, picks one of three watchdog clock sources and enables the timer. From then on a down-counter, advanced once every four pulses of the chosen source, must be refreshed by a two-write feed before it runs out. If the counter expires, or software writes a malformed feed, the block raises a fault. Depending on a mode bit, the fault becomes a one-cycle system reset request or a level interrupt.

Enabling cannot be undone by software. Only the system reset input clears it, and the system is expected to drive that input from the reset request. A timeout flag records every fault. It is reset only by a separate power-on reset input or by software, so code that starts after a watchdog reset can tell why it restarted.

The three oscillators are not clocks here. They appear as synchronous pulse enables in the single `clk` domain, so the source selection is a pulse multiplexer.

Top module: `wdog_guard`

## Requirements
- R1: After `rst_n` and `por_n` are both low on a clock edge, the register reads are as follows. The control register (address 0) reads 0. The reload register (address 1) reads 256. The source register (address 3) reads 0. The counter (address 4, read-only) reads 256. `wd_reset_req` and `wd_irq` are low.
- R2: Writing 1 to control bit 0 enables the timer and loads the counter from the reload register. At that edge the prescaler is cleared. While enabled, the counter drops by one on every fourth pulse of the selected source. If the selected source pulses on every cycle, the fault occurs on the edge exactly 4 × reload cycles after the enabling write.
- R3: A value below 256 written to the reload register (address 1) is stored and read back as 256. Values of 256 and above are stored unchanged.
- R4: Once control bit 0 is set, writing 0 to it has no effect. Only `rst_n` clears it.
- R5: Source register bits [1:0] select the pulse input that drives the prescaler. The codes are 0 for `src_irc_en`, 1 for `src_rtc_en`, 2 for `src_pclk_en` and 3 for none, which means no counting. Pulses on inputs that are not selected are ignored.
- R6: Writing the source register with bit 31 set locks it. Later writes to the source register are then ignored until `rst_n`.
- R7: A valid feed is a write of 0xAA and then a write of 0x55 to the feed register (address 2), compared on data bits [7:0]. There must be no other register access between the two writes. A valid feed reloads the counter and clears the prescaler, and it raises no fault.
- R8: While the timer is enabled, two kinds of access raise a fault. The first is a feed write whose low byte is not 0xAA, when no 0xAA is pending. The second is any register read or write, other than a 0x55 feed write, that follows a pending 0xAA. While the timer is disabled, no such access raises a fault.
- R9: With control bit 1 = 0 (reset mode), a fault drives `wd_reset_req` high for exactly one cycle. The pulse starts after the fault edge.
- R10: With control bit 1 = 1 (interrupt mode), a fault raises no reset request. In this mode `wd_irq` is high while the timeout flag is set.
- R11: Control bit 2 is the timeout flag. Every fault sets it. It keeps its value through `rst_n`. It is cleared by `por_n` low or by a control write with bit 2 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all logic is on its rising edge |
| rst_n | input | 1 | Synchronous active-low system reset (also the watchdog reset path) |
| por_n | input | 1 | Synchronous active-low power-on reset; clears the timeout flag |
| src_irc_en | input | 1 | Pulse enable from the internal RC oscillator |
| src_rtc_en | input | 1 | Pulse enable from the RTC oscillator |
| src_pclk_en | input | 1 | Pulse enable from the peripheral clock |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (counts as an access for the feed sequence) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| wd_reset_req | output | 1 | One-cycle system reset request |
| wd_irq | output | 1 | Watchdog interrupt, level |

## Verification
Register writes take effect on the edge inside the write, and read data is combinational. The bench therefore samples a written value on the following read cycle, and it samples a fault flag or reset pulse at the negedge right after the edge that caused it. An expiry falls 4 × reload edges after the enabling edge. The bench counts that many negedges: it checks that the output is still low one cycle before the expiry, high on the expiry cycle and, for the reset request, low again one cycle later. In the source sweep, the selected input is driven for a known number of edges and the counter is read afterwards. The expected value is the reload minus that number of edges divided by four.

// File: rtl/wdog_pkg.sv
// Shared constants and types for the watchdog.
// Assumes a single clock domain; source "clocks" arrive as pulse enables.
package wdog_pkg;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_RELOAD = 3'd1,
        A_FEED   = 3'd2,
        A_CLKSEL = 3'd3,
        A_COUNT  = 3'd4
    } wd_addr_e;

    typedef enum logic [1:0] {
        SRC_IRC  = 2'd0,
        SRC_RTC  = 2'd1,
        SRC_PCLK = 2'd2,
        SRC_NONE = 2'd3
    } wd_src_e;

    localparam logic [7:0] FEED_KEY_A = 8'hAA;
    localparam logic [7:0] FEED_KEY_B = 8'h55;
endpackage

// File: rtl/wdog_clk_sel.sv
// Picks one of three source pulse enables and divides it by PRESCALE.
// Assumes the pulses are synchronous to clk; 'restart' clears the prescaler.
module wdog_clk_sel
    import wdog_pkg::*;
#(
    parameter int unsigned PRESCALE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] src_en,
    input  wd_src_e    sel,
    input  logic       restart,
    output logic       tick
);
    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRESCALE - 1);

    logic             pulse;
    logic [PRE_W-1:0] pre_q;

    // Source multiplexer: route the selected pulse enable.
    always_comb begin
        case (sel)
            SRC_IRC:  pulse = src_en[0];
            SRC_RTC:  pulse = src_en[1];
            SRC_PCLK: pulse = src_en[2];
            default:  pulse = 1'b0;
        endcase
    end

    // Prescaler: count source pulses, wrap at PRESCALE.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
        end else if (pulse) begin
            pre_q <= (pre_q == PRE_MAX) ? '0 : pre_q + 1'b1;
        end
    end

    assign tick = pulse && (pre_q == PRE_MAX) && !restart;
endmodule

// File: rtl/wdog_feed_seq.sv
// Tracks the two-write feed sequence.
// Assumes feed_wr is only high together with acc (a feed write is an access).
module wdog_feed_seq
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic       feed_wr,
    input  logic [7:0] wdata,
    output logic       feed_ok,
    output logic       feed_bad
);
    logic armed_q;

    // Classify the current access against the pending state.
    always_comb begin
        feed_ok  = armed_q && feed_wr && (wdata == FEED_KEY_B);
        feed_bad = (armed_q && acc && !feed_ok) ||
                   (!armed_q && feed_wr && (wdata != FEED_KEY_A));
    end

    // Pending state: set by a first-key write, dropped by any other access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (acc) begin
            armed_q <= !armed_q && feed_wr && (wdata == FEED_KEY_A);
        end
    end
endmodule

// File: rtl/wdog_counter.sv
// Down-counter: loads on 'load', decrements on 'tick' while 'run',
// flags 'expire' when a tick would take it from 1 to 0 and reloads instead.
module wdog_counter #(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned RST_VAL = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    assign expire = run && tick && !load && (cnt_q == CNT_W'(1));
    assign cnt    = cnt_q;

    // Count state: load has priority, then tick-driven decrement or reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load || expire) begin
            cnt_q <= load_val;
        end else if (run && tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdog_guard.sv
// Watchdog top: register file, one-way enable, source lock, fault routing.
// Assumes rst_n is driven by the system from wd_reset_req; por_n only at power-up.
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned MIN_RELOAD = 256,
    parameter int unsigned PRESCALE   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              src_irc_en,
    input  logic              src_rtc_en,
    input  logic              src_pclk_en,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              wd_reset_req,
    output logic              wd_irq
);
    localparam logic [CNT_W-1:0] RELOAD_FLOOR = CNT_W'(MIN_RELOAD);
    localparam int unsigned      LOCK_BIT     = CNT_W - 1;

    logic             en_q, mode_q, flag_q, lock_q, req_q;
    logic [CNT_W-1:0] reload_q, cnt_q;
    wd_src_e          sel_q;
    logic             wr_ctrl, wr_reload, wr_feed, wr_clksel;
    logic             load, tick, expire, feed_ok, feed_bad, fault;

    // Address decode for write strobes.
    always_comb begin
        wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
        wr_reload = reg_wr && (reg_addr == A_RELOAD);
        wr_feed   = reg_wr && (reg_addr == A_FEED);
        wr_clksel = reg_wr && (reg_addr == A_CLKSEL);
    end

    assign load  = (wr_ctrl && reg_wdata[0] && !en_q) || feed_ok;
    assign fault = en_q && (expire || feed_bad);

    // Control state: sticky enable, mode bit, one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= en_q | reg_wdata[0];
                mode_q <= reg_wdata[1];
            end
            req_q <= fault && !mode_q;
        end
    end

    // Timeout flag: only power-on reset or a software zero clears it.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else if (fault) begin
            flag_q <= 1'b1;
        end else if (wr_ctrl && !reg_wdata[2]) begin
            flag_q <= 1'b0;
        end
    end

    // Reload register with floor clamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= RELOAD_FLOOR;
        end else if (wr_reload) begin
            reload_q <= (reg_wdata < RELOAD_FLOOR) ? RELOAD_FLOOR : reg_wdata;
        end
    end

    // Source select with one-way lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= SRC_IRC;
            lock_q <= 1'b0;
        end else if (wr_clksel && !lock_q) begin
            sel_q  <= wd_src_e'(reg_wdata[1:0]);
            lock_q <= reg_wdata[LOCK_BIT];
        end
    end

    wdog_clk_sel #(.PRESCALE(PRESCALE)) u_clk_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_en  ({src_pclk_en, src_rtc_en, src_irc_en}),
        .sel     (sel_q),
        .restart (load),
        .tick    (tick)
    );

    wdog_feed_seq u_feed (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (reg_wr || reg_rd),
        .feed_wr  (wr_feed),
        .wdata    (reg_wdata[7:0]),
        .feed_ok  (feed_ok),
        .feed_bad (feed_bad)
    );

    wdog_counter #(.CNT_W(CNT_W), .RST_VAL(MIN_RELOAD)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en_q),
        .load     (load),
        .load_val (reload_q),
        .tick     (tick),
        .cnt      (cnt_q),
        .expire   (expire)
    );

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            A_CTRL:   reg_rdata = {{(CNT_W-3){1'b0}}, flag_q, mode_q, en_q};
            A_RELOAD: reg_rdata = reload_q;
            A_CLKSEL: reg_rdata = {lock_q, {(CNT_W-3){1'b0}}, sel_q};
            A_COUNT:  reg_rdata = cnt_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign wd_reset_req = req_q;
    assign wd_irq       = flag_q && mode_q;
endmodule

// File: rtl/wdog_guard_checker.sv
// Property checker for wdog_guard, attached by bind below.
module wdog_guard_checker #(
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned MIN_RELOAD = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por_n,
    input logic             en_q,
    input logic             mode_q,
    input logic             flag_q,
    input logic             lock_q,
    input logic [1:0]       sel_q,
    input logic [CNT_W-1:0] reload_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             wd_reset_req
);
    a_r4_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);

    a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> (lock_q && $stable(sel_q)));

    a_r3_reload_floor: assert property (@(posedge clk) disable iff (!rst_n)
        reload_q >= CNT_W'(MIN_RELOAD));

    a_r2_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0);

    a_r11_req_sets_flag: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        wd_reset_req |-> flag_q);

    a_r10_no_req_in_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_req |-> !$past(mode_q));
endmodule

bind wdog_guard wdog_guard_checker #(.CNT_W(CNT_W), .MIN_RELOAD(MIN_RELOAD)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_n        (por_n),
    .en_q         (en_q),
    .mode_q       (mode_q),
    .flag_q       (flag_q),
    .lock_q       (lock_q),
    .sel_q        (sel_q),
    .reload_q     (reload_q),
    .cnt_q        (cnt_q),
    .wd_reset_req (wd_reset_req)
);

// File: tb/wdog_guard_test.sv
// Self-checking bench for wdog_guard: register, timing and fault sweeps.
module wdog_guard_test;
    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0, por_n = 1'b0;
    logic [2:0]   src = 3'b000;
    logic         reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         wd_reset_req, wd_irq;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] v;

    always #5 clk = ~clk;

    wdog_guard uut (
        .clk (clk), .rst_n (rst_n), .por_n (por_n),
        .src_irc_en (src[0]), .src_rtc_en (src[1]), .src_pclk_en (src[2]),
        .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .wd_reset_req (wd_reset_req), .wd_irq (wd_irq)
    );

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic sys_reset(input logic with_por);
        @(negedge clk);
        rst_n = 1'b0; por_n = !with_por;
        @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        sys_reset(1'b1);
        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd1, v); chk("R1 reload", v, 256);
        rd(3'd3, v); chk("R1 clksel", v, 0);
        rd(3'd4, v); chk("R1 count", v, 256);
        chk("R1 req", {31'd0, wd_reset_req}, 0);
        chk("R1 irq", {31'd0, wd_irq}, 0);

        // R3 reload floor
        wr(3'd1, 10);  rd(3'd1, v); chk("R3 10", v, 256);
        wr(3'd1, 255); rd(3'd1, v); chk("R3 255", v, 256);
        wr(3'd1, 256); rd(3'd1, v); chk("R3 256", v, 256);
        wr(3'd1, 257); rd(3'd1, v); chk("R3 257", v, 257);

        // R4 one-way enable
        wr(3'd0, 1); wr(3'd0, 0); rd(3'd0, v); chk("R4 stays", v & 1, 1);
        sys_reset(1'b1); rd(3'd0, v); chk("R4 rst clears", v, 0);

        // R6 lock
        wr(3'd3, 32'h8000_0001); wr(3'd3, 2); rd(3'd3, v); chk("R6 locked", v, 32'h8000_0001);
        sys_reset(1'b0); wr(3'd3, 2); rd(3'd3, v); chk("R6 unlock by rst", v, 2);

        // R5 source sweep: 40 pulses on one input give 10 ticks if selected
        for (int sel = 0; sel < 4; sel++) begin
            for (int s = 0; s < 3; s++) begin
                sys_reset(1'b1);
                wr(3'd3, W'(sel));
                wr(3'd0, 1);
                src = 3'(1 << s);
                repeat (40) @(negedge clk);
                src = 3'b000;
                rd(3'd4, v);
                chk($sformatf("R5 sel%0d src%0d", sel, s), v, (sel == s) ? 246 : 256);
            end
        end

        // R2 + R3 + R9: reload written below floor, reset-mode expiry at 4*256
        sys_reset(1'b1);
        wr(3'd1, 10); wr(3'd3, 2);
        src = 3'b100;
        wr(3'd0, 1);
        repeat (4*256 - 1) @(negedge clk);
        chk("R2 before expiry", {31'd0, wd_reset_req}, 0);
        @(negedge clk);
        chk("R9 req on expiry", {31'd0, wd_reset_req}, 1);
        @(negedge clk);
        chk("R9 req one cycle", {31'd0, wd_reset_req}, 0);
        src = 3'b000;

        // R11 flag survives rst_n, cleared by por_n
        sys_reset(1'b0); rd(3'd0, v); chk("R11 flag after rst", v, 4);
        sys_reset(1'b1); rd(3'd0, v); chk("R11 por clears", v, 0);

        // R2 + R10: interrupt mode with reload 300
        wr(3'd1, 300); wr(3'd3, 2);
        src = 3'b100;
        wr(3'd0, 3);
        repeat (4*300 - 1) @(negedge clk);
        chk("R2 irq before expiry", {31'd0, wd_irq}, 0);
        @(negedge clk);
        chk("R10 irq on expiry", {31'd0, wd_irq}, 1);
        chk("R10 no req", {31'd0, wd_reset_req}, 0);
        repeat (5) @(negedge clk);
        chk("R10 irq holds", {31'd0, wd_irq}, 1);
        src = 3'b000;
        wr(3'd0, 3);
        chk("R11 sw clear", {31'd0, wd_irq}, 0);

        // R7 valid feed reloads counter without fault
        sys_reset(1'b1);
        wr(3'd3, 2); wr(3'd0, 1);
        src = 3'b100;
        repeat (100) @(negedge clk);
        wr(3'd2, 32'hAA); wr(3'd2, 32'h55);
        src = 3'b000;
        rd(3'd4, v); chk("R7 reloaded", v, 256);
        rd(3'd0, v); chk("R7 no fault", v, 1);

        // R8 bad feeds in interrupt mode
        sys_reset(1'b1);
        wr(3'd0, 3);
        wr(3'd2, 32'h12);
        chk("R8 wrong key irq", {31'd0, wd_irq}, 1);
        wr(3'd0, 3); rd(3'd0, v); chk("R8 cleared", v, 3);
        wr(3'd2, 32'hAA); rd(3'd0, v);
        chk("R8 read breaks seq", {31'd0, wd_irq}, 1);
        wr(3'd0, 3);
        wr(3'd2, 32'hAA); wr(3'd1, 500);
        chk("R8 write breaks seq", {31'd0, wd_irq}, 1);

        // R8 disabled: no fault
        sys_reset(1'b1);
        wr(3'd2, 32'h12); rd(3'd0, v); chk("R8 disabled no fault", v, 0);

        // R9 bad feed in reset mode pulses request
        wr(3'd0, 1);
        wr(3'd2, 32'h33);
        chk("R9 req on bad feed", {31'd0, wd_reset_req}, 1);
        @(negedge clk);
        chk("R9 req drops", {31'd0, wd_reset_req}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule